// File: doc/BRIEF.md
# Decrement-and-Branch Execution Unit

This unit carries out the two "decrement, then branch if the result is not zero" opcodes of an 8-bit microcontroller core. A start pulse hands it the opcode byte, the one or two bytes that follow it, the current program counter and the processor status word. The unit decodes the operand location, reads the operand once through a simple memory port, writes back the value minus one, and reports the next program counter.

There are two operand forms. In the register form, the operand is one of eight working registers in the bank that the status word selects. In the direct form, the operand is a byte in internal memory named by an address byte. The loop counter wraps from 00h to FFh. When the operand is one of the parallel I/O ports, the unit asks the memory side for the port's output latch rather than its pins.

The instruction takes two machine cycles of a parameterised number of clocks. It ends with a single done cycle that carries the write-back and the next program counter. The status word is passed through unchanged.

Top module: `dbnz_exec_unit`

## Requirements
- R1: An opcode whose upper five bits are 11011 selects the register form. The operand address is {3'b000, psw_in[4], psw_in[3], opcode[2:0]}, with psw_in[4] as the high bank bit. The displacement is insn_b1.
- R2: Opcode D5h selects the direct form. insn_b1 is the operand address and insn_b2 is the displacement.
- R3: In the done cycle, mem_we is 1 and mem_wdata is the operand read minus one, modulo 256, so 00h becomes FFh. mem_addr is the operand address.
- R4: In the done cycle, next_pc is pc_in + L + sign-extended displacement, modulo 2^16, when mem_wdata is nonzero. It is pc_in + L when mem_wdata is zero. L is 2 for the register form and 3 for the direct form.
- R5: A run lasts two machine cycles of CLKS_PER_MC (default 12) clocks. done is high exactly once, in the 24th clock after the edge that accepts start. mem_rd is high only in the first of those clocks, and mem_we only together with done.
- R6: When the operand address is 80h, 90h, A0h or B0h, mem_rd_latch is 1 with the read. For every other operand address it is 0.
- R7: psw_out equals psw_in at all times; no status bit is changed.
- R8: A start pulse is ignored while a run is in progress, and also when the opcode is neither form. In either case there is no extra done, no extra write and no change to memory.
- R9: After reset, busy, done, mem_rd, mem_rd_latch and mem_we are 0 and next_pc is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle and the opcode is valid |
| insn_op | input | 8 | Opcode byte |
| insn_b1 | input | 8 | First byte after the opcode |
| insn_b2 | input | 8 | Second byte after the opcode |
| pc_in | input | 16 | Address of the opcode byte |
| psw_in | input | 8 | Status word; bits 4:3 select the bank |
| mem_rdata | input | 8 | Read data returned by the memory side in the same cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Final cycle of a run |
| next_pc | output | 16 | Next program counter, valid with done, else 0 |
| psw_out | output | 8 | Status word, unchanged |
| mem_addr | output | 8 | Operand address during a run |
| mem_rd | output | 1 | Operand read strobe |
| mem_rd_latch | output | 1 | Read the port output latch instead of the pins |
| mem_we | output | 1 | Write-back strobe |
| mem_wdata | output | 8 | Decremented operand |

## Verification
The assertions assume that the memory side returns mem_rdata in the same cycle as mem_rd. They also assume that mem_rdata is a known value whenever it is read. The bench's memory model is a combinational array with separate pin values for the four port addresses, so both assumptions always hold. It is written only at clock edges, through one process, which serves both the unit's write-back and the bench's preloads. The instruction bytes, pc_in and psw_in are held steady from the start pulse until done. The one exception is the deliberate second start pulse that tests R8, and the design must not act on it.

// File: rtl/dbnz_pkg.sv
package dbnz_pkg;
  localparam int PC_W = 16;

  typedef enum logic [1:0] {FORM_NONE, FORM_REG, FORM_DIR} form_e;

  function automatic logic [7:0] dec_wrap(input logic [7:0] v);
    return v - 8'd1;
  endfunction

  function automatic logic [PC_W-1:0] sext_disp(input logic [7:0] d);
    return {{(PC_W-8){d[7]}}, d};
  endfunction

  function automatic logic [PC_W-1:0] pc_advance(input logic [PC_W-1:0] pc,
                                                 input logic [1:0] len);
    return pc + {{(PC_W-2){1'b0}}, len};
  endfunction

  function automatic logic [PC_W-1:0] pc_branch(input logic [PC_W-1:0] pc_next,
                                                input logic [7:0] d);
    return pc_next + sext_disp(d);
  endfunction

  function automatic logic is_io_port(input logic [7:0] a);
    return (a[7:6] == 2'b10) && (a[3:0] == 4'h0);
  endfunction
endpackage

// File: rtl/dbnz_decode.sv
module dbnz_decode
  import dbnz_pkg::*;
(
  input  logic [7:0] op,
  input  logic [7:0] b1,
  input  logic [7:0] b2,
  input  logic [1:0] bank,
  output logic       valid,
  output logic [7:0] addr,
  output logic [7:0] disp,
  output logic [1:0] len
);
  form_e form;

  always_comb begin
    form = FORM_NONE;
    if (op[7:3] == 5'b11011) form = FORM_REG;
    else if (op == 8'hD5)    form = FORM_DIR;
  end

  always_comb begin
    addr = 8'h00;
    disp = 8'h00;
    len  = 2'd0;
    unique case (form)
      FORM_REG: begin
        addr = {3'b000, bank, op[2:0]};
        disp = b1;
        len  = 2'd2;
      end
      FORM_DIR: begin
        addr = b1;
        disp = b2;
        len  = 2'd3;
      end
      default: ;
    endcase
  end

  assign valid = (form != FORM_NONE);
endmodule

// File: rtl/dbnz_seq.sv
module dbnz_seq #(
  parameter int TOTAL = 24,
  localparam int CNT_W = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic valid,
  output logic busy,
  output logic accept,
  output logic rd_strobe,
  output logic fin_strobe
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

  assign accept = start && valid && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      busy_q <= accept;
      cnt_q  <= '0;
    end else if (cnt_q == LAST) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy       = busy_q;
  assign rd_strobe  = busy_q && (cnt_q == '0);
  assign fin_strobe = busy_q && (cnt_q == LAST);
endmodule

// File: rtl/dbnz_datapath.sv
module dbnz_datapath
  import dbnz_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [7:0]      addr_in,
  input  logic [7:0]      disp_in,
  input  logic [1:0]      len_in,
  input  logic [PC_W-1:0] pc_in,
  input  logic            rd_strobe,
  input  logic [7:0]      rdata,
  output logic [7:0]      addr,
  output logic [7:0]      result,
  output logic            taken,
  output logic [PC_W-1:0] fall_pc,
  output logic [PC_W-1:0] target_pc
);
  logic [7:0]      addr_q, disp_q, opnd_q;
  logic [1:0]      len_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      disp_q <= '0;
      len_q  <= '0;
      pc_q   <= '0;
      opnd_q <= '0;
    end else begin
      if (load) begin
        addr_q <= addr_in;
        disp_q <= disp_in;
        len_q  <= len_in;
        pc_q   <= pc_in;
      end
      if (rd_strobe) opnd_q <= rdata;
    end
  end

  assign addr      = addr_q;
  assign result    = dec_wrap(opnd_q);
  assign taken     = (result != 8'h00);
  assign fall_pc   = pc_advance(pc_q, len_q);
  assign target_pc = pc_branch(fall_pc, disp_q);
endmodule

// File: rtl/dbnz_exec_unit.sv
module dbnz_exec_unit
  import dbnz_pkg::*;
#(
  parameter int CLKS_PER_MC = 12,
  parameter int MC_PER_INSN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [7:0]      insn_op,
  input  logic [7:0]      insn_b1,
  input  logic [7:0]      insn_b2,
  input  logic [PC_W-1:0] pc_in,
  input  logic [7:0]      psw_in,
  input  logic [7:0]      mem_rdata,
  output logic            busy,
  output logic            done,
  output logic [PC_W-1:0] next_pc,
  output logic [7:0]      psw_out,
  output logic [7:0]      mem_addr,
  output logic            mem_rd,
  output logic            mem_rd_latch,
  output logic            mem_we,
  output logic [7:0]      mem_wdata
);
  localparam int TOTAL_CLKS = CLKS_PER_MC * MC_PER_INSN;

  logic            dec_valid;
  logic [7:0]      dec_addr, dec_disp;
  logic [1:0]      dec_len;
  logic            accept, rd_strobe, fin_strobe;
  logic [7:0]      op_addr, result;
  logic            branch_taken;
  logic [PC_W-1:0] fallthru_pc, target_pc;

  dbnz_decode u_dec (
    .op(insn_op), .b1(insn_b1), .b2(insn_b2), .bank(psw_in[4:3]),
    .valid(dec_valid), .addr(dec_addr), .disp(dec_disp), .len(dec_len)
  );

  dbnz_seq #(.TOTAL(TOTAL_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .valid(dec_valid),
    .busy(busy), .accept(accept), .rd_strobe(rd_strobe), .fin_strobe(fin_strobe)
  );

  dbnz_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .addr_in(dec_addr), .disp_in(dec_disp), .len_in(dec_len), .pc_in(pc_in),
    .rd_strobe(rd_strobe), .rdata(mem_rdata),
    .addr(op_addr), .result(result), .taken(branch_taken),
    .fall_pc(fallthru_pc), .target_pc(target_pc)
  );

  assign done         = fin_strobe;
  assign mem_addr     = busy ? op_addr : 8'h00;
  assign mem_rd       = rd_strobe;
  assign mem_rd_latch = rd_strobe && is_io_port(op_addr);
  assign mem_we       = fin_strobe;
  assign mem_wdata    = fin_strobe ? result : 8'h00;
  assign next_pc      = !fin_strobe ? '0 : (branch_taken ? target_pc : fallthru_pc);
  assign psw_out      = psw_in;
endmodule

// File: rtl/dbnz_exec_chk.sv
module dbnz_exec_chk #(
  parameter int TOTAL = 24
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mem_rd,
  input logic        mem_rd_latch,
  input logic        mem_we,
  input logic [7:0]  mem_rdata,
  input logic [7:0]  mem_wdata,
  input logic [15:0] next_pc,
  input logic        branch_taken,
  input logic [15:0] fallthru_pc
);
  logic [7:0]  cap_q;
  logic [31:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q <= '0;
      run_q <= '0;
    end else begin
      if (mem_rd) cap_q <= mem_rdata;
      run_q <= busy ? run_q + 1 : 0;
    end
  end

  assert_wb_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_wdata == 8'(cap_q - 8'd1)));
  assert_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (branch_taken == (mem_wdata != 8'h00)));
  assert_fallthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mem_wdata == 8'h00) |-> (next_pc == fallthru_pc));
  assert_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_q == 32'(TOTAL - 1)));
  assert_rd_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (run_q == 0));
  assert_we_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> done);
  assert_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_latch |-> mem_rd);
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_we && !done));
endmodule

bind dbnz_exec_unit dbnz_exec_chk #(.TOTAL(TOTAL_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_rd(mem_rd),
  .mem_rd_latch(mem_rd_latch), .mem_we(mem_we), .mem_rdata(mem_rdata),
  .mem_wdata(mem_wdata), .next_pc(next_pc), .branch_taken(branch_taken),
  .fallthru_pc(fallthru_pc)
);

// File: tb/tb_dbnz_exec_unit.sv
`timescale 1ns/1ps
module tb_dbnz_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  insn_op = 8'h00, insn_b1 = 8'h00, insn_b2 = 8'h00, psw_in = 8'h00;
  logic [15:0] pc_in = 16'h0000;
  logic [7:0]  mem_rdata;
  logic        busy, done, mem_rd, mem_rd_latch, mem_we;
  logic [15:0] next_pc;
  logic [7:0]  psw_out, mem_addr, mem_wdata;

  logic [7:0]  ram  [0:255];
  logic [7:0]  pins [0:3];
  logic        poke_en = 1'b0;
  logic [7:0]  poke_addr = 8'h00, poke_data = 8'h00;

  int n_chk = 0, n_fail = 0;
  int r_cycles, r_rd, r_we, r_done_after;
  logic [15:0] r_npc;
  logic r_latch, r_psw_ok;

  always #2.5 clk = ~clk;

  dbnz_exec_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .insn_op(insn_op), .insn_b1(insn_b1),
    .insn_b2(insn_b2), .pc_in(pc_in), .psw_in(psw_in), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .next_pc(next_pc), .psw_out(psw_out),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rd_latch(mem_rd_latch),
    .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  function automatic logic port_addr(input logic [7:0] a);
    return a == 8'h80 || a == 8'h90 || a == 8'hA0 || a == 8'hB0;
  endfunction

  assign mem_rdata = (port_addr(mem_addr) && !mem_rd_latch) ? pins[mem_addr[5:4]]
                                                            : ram[mem_addr];

  always @(posedge clk) begin
    if (mem_we)  ram[mem_addr]  <= mem_wdata;
    if (poke_en) ram[poke_addr] <= poke_data;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = a; poke_data = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  function automatic logic [15:0] exp_pc(input logic [15:0] pc, input int len,
                                         input logic [7:0] disp, input logic [7:0] res);
    int t;
    t = int'(pc) + len;
    if (res != 8'h00) t = t + (disp[7] ? int'(disp) - 256 : int'(disp));
    return 16'(t);
  endfunction

  task automatic run_insn(input logic [7:0] op, b1, b2, input logic [15:0] pc,
                          input logic [7:0] psw, input logic intrude);
    r_rd = 0; r_we = 0; r_latch = 1'b0; r_psw_ok = 1'b1; r_npc = 16'h0; r_done_after = 0;
    @(negedge clk);
    insn_op = op; insn_b1 = b1; insn_b2 = b2; pc_in = pc; psw_in = psw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r_cycles = 1;
    while (r_cycles < 100) begin
      if (mem_rd) begin r_rd++; r_latch = mem_rd_latch; end
      if (mem_we) r_we++;
      if (psw_out !== psw_in) r_psw_ok = 1'b0;
      if (done) break;
      @(negedge clk);
      r_cycles++;
      start = 1'b0;
      if (intrude && r_cycles == 5) begin
        insn_op = 8'hD5; insn_b1 = 8'h70; insn_b2 = 8'h04; start = 1'b1;
      end
    end
    r_npc = next_pc;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done || mem_we) r_done_after++;
    end
  endtask

  task automatic t_reset;
    chk("R9 busy", busy, 0);
    chk("R9 done", done, 0);
    chk("R9 rd/we", {mem_rd, mem_rd_latch, mem_we}, 0);
    chk("R9 next_pc", next_pc, 0);
  endtask

  task automatic t_reg_bank0_taken;
    poke(8'h02, 8'h08);
    run_insn(8'hDA, 8'h10, 8'h00, 16'h0100, 8'h00, 1'b0);
    chk("R5 done cycle", r_cycles, 24);
    chk("R5 single read", r_rd, 1);
    chk("R5 single write", r_we, 1);
    chk("R5 no extra done", r_done_after, 0);
    chk("R1 R3 reg R2 bank0", ram[8'h02], 8'h07);
    chk("R4 taken reg", r_npc, exp_pc(16'h0100, 2, 8'h10, 8'h07));
    chk("R7 psw passthrough", r_psw_ok, 1);
  endtask

  task automatic t_reg_bank3_zero;
    poke(8'h1F, 8'h01);
    poke(8'h07, 8'h55);
    run_insn(8'hDF, 8'h80, 8'h00, 16'h2000, 8'hD9, 1'b0);
    chk("R1 bank3 R7", ram[8'h1F], 8'h00);
    chk("R1 bank0 R7 untouched", ram[8'h07], 8'h55);
    chk("R4 fall through reg", r_npc, 16'h2002);
    chk("R7 psw all bits", r_psw_ok, 1);
  endtask

  task automatic t_dir_wrap;
    poke(8'h40, 8'h00);
    run_insn(8'hD5, 8'h40, 8'hFE, 16'h0300, 8'h00, 1'b0);
    chk("R3 wrap 00 to FF", ram[8'h40], 8'hFF);
    chk("R2 R4 direct back branch", r_npc, exp_pc(16'h0300, 3, 8'hFE, 8'hFF));
    chk("R6 no latch for 40h", r_latch, 0);
  endtask

  task automatic t_dir_port;
    poke(8'h90, 8'h05);
    pins[1] = 8'hAA;
    run_insn(8'hD5, 8'h90, 8'h20, 16'h0400, 8'h00, 1'b0);
    chk("R6 latch strobe", r_latch, 1);
    chk("R6 value from latch", ram[8'h90], 8'h04);
  endtask

  task automatic t_pc_wrap;
    poke(8'h0B, 8'h03);
    run_insn(8'hDB, 8'h10, 8'h00, 16'hFFFE, 8'h08, 1'b0);
    chk("R4 pc wraps", r_npc, 16'h0010);
    chk("R1 bank1 R3", ram[8'h0B], 8'h02);
  endtask

  task automatic t_sequence;
    poke(8'h40, 8'h01); poke(8'h50, 8'h70); poke(8'h60, 8'h15);
    run_insn(8'hD5, 8'h40, 8'h30, 16'h1000, 8'h00, 1'b0);
    chk("R4 first not taken", r_npc, 16'h1003);
    run_insn(8'hD5, 8'h50, 8'h30, 16'h1003, 8'h00, 1'b0);
    chk("R4 second taken", r_npc, 16'h1036);
    chk("R3 seq 40h", ram[8'h40], 8'h00);
    chk("R3 seq 50h", ram[8'h50], 8'h6F);
    chk("R3 seq 60h", ram[8'h60], 8'h15);
  endtask

  task automatic t_ignored;
    int seen;
    poke(8'h70, 8'h09);
    poke(8'h03, 8'h04);
    run_insn(8'hDB, 8'h02, 8'h00, 16'h0500, 8'h00, 1'b1);
    chk("R8 start while busy no extra done", r_done_after, 0);
    chk("R8 busy intrusion mem", ram[8'h70], 8'h09);
    chk("R8 first run intact", ram[8'h03], 8'h03);
    seen = 0;
    @(negedge clk);
    insn_op = 8'hD4; insn_b1 = 8'h70; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (busy || done || mem_we) seen++;
      @(negedge clk);
    end
    chk("R8 invalid opcode idle", seen, 0);
    chk("R8 invalid opcode mem", ram[8'h70], 8'h09);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    for (int i = 0; i < 4; i++) pins[i] = 8'h33;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reg_bank0_taken();
    t_reg_bank3_zero();
    t_dir_wrap();
    t_dir_port();
    t_pc_wrap();
    t_sequence();
    t_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule